// File: doc/BRIEF.md
# SPI Operation Sequencer

This block is a small programmable controller that runs a list of eight byte-wide operations to build SPI transactions without host intervention per byte. Each operation occupies one slot of a 64-bit operation list, slot 0 in the top byte. The upper nibble of a slot picks the operation. The low nibble is a parameter: a responder select code, a segment size handed to the external count decoder, or a branch target slot. Operations can select or release the responder, issue the first (N1) and second (N2) shift segments of a frame, branch on a receive-data comparison, and loop on two counters.

The physical shifter sits outside the block and is reached through a frame request and done handshake. The block tells the shifter whether the frame carries an N1 part, an N2 part, or both, and whether it loads the receive register. Whether each segment transmits or receives comes from an external count decoder. The match result of the receive-data comparison also comes from outside. The block tracks whether the transmit and receive registers are full. When a segment needs data that is not there, or needs room that is not there, the block stalls. A host write to the transmit register, or a host read of the receive register, lets it resume at the same slot. A two-step key written to a reset-control field restarts the whole controller.

Top module: `spi_op_sequencer`

## Requirements
- R1: After reset: sequencer idle (state code 0), index 0, chip select released (`cs_n`=1), shifter idle (code 0), error clear, both full flags clear, no frame request. A host transmit write sets `tdr_full` and clears the error flag. If the sequencer is idle, the write also starts it at index 0.
- R2: Opcode 0x00 stops the sequence. The shifter goes idle, both loop counters are cleared, the sequencer goes idle, and the index stays on the stop slot.
- R3: Opcode 0x1N with N=0 releases chip select, sets the shifter to done (code 5) and advances. N=1 asserts chip select, sets the shifter to start (code 1), clears the N1-done flag and advances. Any other N sets the error flag, sets the shifter idle and stops at that slot.
- R4: A shift N1 (0x3M) while the shifter is idle or done sets the error flag and stops. A shift N2 (0x4M) with no N1 completed since the last select also sets the error flag and stops.
- R5: When the slot after an N1 holds an N2, the N1 is not sent alone. The next frame carries both parts (`frame_n1`=1, `frame_n2`=1).
- R6: An N1 that transmits while `tdr_full`=0, or any segment that receives while `rdr_full`=1, stalls. A 0x6N branch while `rdr_full`=0 also stalls. A stall means sequencer state 3 and shifter wait (code 4). A host write or read during a stall resumes at the same index.
- R7: Opcode 0x6N with `rdr_full`=1 clears `rdr_full`. On a match it advances; on a mismatch it jumps to slot N.
- R8: Opcodes 0x7N and 0x8N use loop counters 0 and 1 respectively. While the counter differs from its compare field, the branch jumps to slot N and increments the counter. Otherwise it advances. A compare of 0 makes the branch a no-op, so a loop body runs compare+1 times.
- R9: Advancing past slot 7 without a stop makes the sequencer idle, sets the index to 0 and clears both loop counters.
- R10: Writing 0x5 and then 0xA to the reset-control field restarts the controller to its reset state. Any other second value leaves all state unchanged.
- R11: `frame_req` stays high until `frame_done`. A done for a receiving frame sets `rdr_full`. A transmitting segment clears `tdr_full` when it is issued. A host read clears `rdr_full`.
- R12: Opcode 0x5x, and upper nibbles 0x2 and 0x9 to 0xF, only advance the index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_list | input | SLOTS*OP_W | Operation list, slot 0 in the top byte |
| loop_cmp | input | LOOPS*CNT_W | Loop compare fields, loop 0 in the low bits |
| n1_tx | input | 1 | Decoder: N1 segment transmits |
| n1_rx | input | 1 | Decoder: N1 segment receives |
| n2_tx | input | 1 | Decoder: N2 segment transmits |
| n2_rx | input | 1 | Decoder: N2 segment receives |
| rdr_match | input | 1 | Masked receive-data comparison result |
| tdr_wr | input | 1 | Host write to the transmit register |
| rdr_rd | input | 1 | Host read of the receive register |
| rstctl_wr | input | 1 | Write strobe of the reset-control field |
| rstctl_val | input | 4 | Value written to the reset-control field |
| frame_done | input | 1 | Shifter finished the requested frame |
| frame_req | output | 1 | Frame request to the shifter |
| frame_n1 | output | 1 | Requested frame carries an N1 part |
| frame_n2 | output | 1 | Requested frame carries an N2 part |
| frame_rx | output | 1 | Requested frame loads the receive register |
| cs_n | output | 1 | Responder chip select, active low |
| tdr_full | output | 1 | Transmit register holds unsent data |
| rdr_full | output | 1 | Receive register holds unread data |
| seq_idx | output | IDX_W | Current slot index |
| seq_state | output | 2 | 0 idle, 1 run, 2 frame, 3 stall |
| shift_state | output | 3 | 0 idle, 1 start, 2 N1, 3 N2, 4 wait, 5 done |
| seq_err | output | 1 | Sequencing error flag |

## Verification
The hardest situation to reach is a stall inside a running program followed by a resume that must not rewind the index. Examples are a second N1 finding the transmit register already emptied, or a receive segment finding the previous byte unread. The bench builds programs that drain the flag on purpose, waits for the stall, and checks the index there. It then issues the single host write or read and checks that execution continues from the same slot. Loop counts come from seeded random compare values, and the frames counted by a bench responder are compared with a computed trip count.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;
   typedef enum logic [1:0] {SQ_IDLE = 2'd0, SQ_RUN = 2'd1, SQ_FRAME = 2'd2, SQ_STALL = 2'd3} sq_st_e;
   typedef enum logic [2:0] {SH_IDLE = 3'd0, SH_START = 3'd1, SH_N1 = 3'd2, SH_N2 = 3'd3,
                             SH_WAIT = 3'd4, SH_DONE = 3'd5} sh_st_e;
   localparam logic [3:0] OPN_STOP   = 4'h0;
   localparam logic [3:0] OPN_SEL    = 4'h1;
   localparam logic [3:0] OPN_SH_N1  = 4'h3;
   localparam logic [3:0] OPN_SH_N2  = 4'h4;
   localparam logic [3:0] OPN_BR_RDR = 4'h6;
   localparam logic [3:0] OPN_LOOP0  = 4'h7;
   localparam logic [3:0] RST_KEY_A  = 4'h5;
   localparam logic [3:0] RST_KEY_B  = 4'hA;
endpackage

// File: rtl/seq_slot_dec.sv
module seq_slot_dec
   import spi_seq_pkg::*;
#(
   parameter int SLOTS = 8,
   parameter int OP_W  = 8,
   parameter int IDX_W = 3
) (
   input  logic [SLOTS*OP_W-1:0] op_list,
   input  logic [IDX_W-1:0]      idx,
   output logic [OP_W-1:0]       cur_op,
   output logic                  nxt_is_n2
);
   logic [OP_W-1:0] slot [SLOTS];

   for (genvar g = 0; g < SLOTS; g++) begin : g_slot
      assign slot[g] = op_list[(SLOTS-1-g)*OP_W +: OP_W];
   end

   always_comb begin
      cur_op    = slot[idx];
      nxt_is_n2 = 1'b0;
      if (idx != IDX_W'(SLOTS-1))
         nxt_is_n2 = (slot[idx + 1'b1][7:4] == OPN_SH_N2);
   end
endmodule

// File: rtl/seq_loop_ctr.sv
module seq_loop_ctr #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   input  logic [CNT_W-1:0] cmp,
   output logic             hit
);
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (clr) cnt <= '0;
      else if (inc) cnt <= cnt + 1'b1;
   end

   assign hit = (cnt == cmp);
endmodule

// File: rtl/seq_rst_unlock.sv
module seq_rst_unlock
   import spi_seq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr,
   input  logic [3:0] val,
   output logic       soft_rst
);
   logic armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed    <= 1'b0;
         soft_rst <= 1'b0;
      end else begin
         soft_rst <= wr && armed && (val == RST_KEY_B);
         if (wr) armed <= (val == RST_KEY_A);
      end
   end
endmodule

// File: rtl/spi_op_sequencer.sv
module spi_op_sequencer
   import spi_seq_pkg::*;
#(
   parameter int SLOTS = 8,
   parameter int OP_W  = 8,
   parameter int CNT_W = 4,
   parameter int LOOPS = 2,
   localparam int IDX_W = $clog2(SLOTS)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [SLOTS*OP_W-1:0]  op_list,
   input  logic [LOOPS*CNT_W-1:0] loop_cmp,
   input  logic                   n1_tx,
   input  logic                   n1_rx,
   input  logic                   n2_tx,
   input  logic                   n2_rx,
   input  logic                   rdr_match,
   input  logic                   tdr_wr,
   input  logic                   rdr_rd,
   input  logic                   rstctl_wr,
   input  logic [3:0]             rstctl_val,
   input  logic                   frame_done,
   output logic                   frame_req,
   output logic                   frame_n1,
   output logic                   frame_n2,
   output logic                   frame_rx,
   output logic                   cs_n,
   output logic                   tdr_full,
   output logic                   rdr_full,
   output logic [IDX_W-1:0]       seq_idx,
   output logic [1:0]             seq_state,
   output logic [2:0]             shift_state,
   output logic                   seq_err
);
   if (SLOTS < 2 || (1 << IDX_W) != SLOTS || SLOTS > 16)
      $error("SLOTS must be a power of two from 2 to 16");
   if (OP_W != 8)
      $error("OP_W must be 8");
   if (LOOPS < 1 || LOOPS > 2)
      $error("LOOPS must be 1 or 2");

   sq_st_e           st, st_d;
   sh_st_e           sh, sh_d;
   logic [IDX_W-1:0] idx, idx_d;
   logic             cs_n_q, cs_n_d, err_q, err_d;
   logic             tdr_q, rdr_q, n1_done_q, n1_done_d, n1_pend_q, n1_pend_d;
   logic             fr_n1_q, fr_n1_d, fr_n2_q, fr_n2_d, fr_rx_q, fr_rx_d;
   logic             tdr_clr, rdr_set, rdr_clr, adv, lp_clr, soft_rst, nxt_is_n2, loop_hit;
   logic [LOOPS-1:0] lp_inc, lp_hit;
   logic [OP_W-1:0]  cur_op;
   logic [3:0]       opn, opa;

   seq_slot_dec #(.SLOTS(SLOTS), .OP_W(OP_W), .IDX_W(IDX_W)) u_dec (
      .op_list(op_list), .idx(idx), .cur_op(cur_op), .nxt_is_n2(nxt_is_n2));

   seq_rst_unlock u_unlock (
      .clk(clk), .rst_n(rst_n), .wr(rstctl_wr), .val(rstctl_val), .soft_rst(soft_rst));

   for (genvar g = 0; g < LOOPS; g++) begin : g_loop
      seq_loop_ctr #(.CNT_W(CNT_W)) u_lp (
         .clk(clk), .rst_n(rst_n), .clr(lp_clr | soft_rst), .inc(lp_inc[g]),
         .cmp(loop_cmp[g*CNT_W +: CNT_W]), .hit(lp_hit[g]));
   end

   assign opn = cur_op[7:4];
   assign opa = cur_op[3:0];

   always_comb begin
      st_d = st;  sh_d = sh;  idx_d = idx;  cs_n_d = cs_n_q;  err_d = err_q;
      n1_done_d = n1_done_q;  n1_pend_d = n1_pend_q;
      fr_n1_d = fr_n1_q;  fr_n2_d = fr_n2_q;  fr_rx_d = fr_rx_q;
      tdr_clr = 1'b0;  rdr_set = 1'b0;  rdr_clr = rdr_rd;  adv = 1'b0;
      lp_clr = 1'b0;  lp_inc = '0;  loop_hit = 1'b0;
      unique case (st)
         SQ_IDLE: if (tdr_wr) begin
            st_d = SQ_RUN; idx_d = '0; err_d = 1'b0;
         end
         SQ_STALL: if (tdr_wr || rdr_rd) begin
            st_d = SQ_RUN;
            if (tdr_wr) err_d = 1'b0;
         end
         SQ_FRAME: if (frame_done) begin
            st_d = SQ_RUN; rdr_set = fr_rx_q; adv = 1'b1;
            if (fr_n2_q) n1_pend_d = 1'b0;
            else         n1_done_d = 1'b1;
         end
         default: begin
            case (opn)
               OPN_STOP: begin
                  sh_d = SH_IDLE; lp_clr = 1'b1; st_d = SQ_IDLE;
               end
               OPN_SEL: begin
                  if (opa == 4'd0) begin
                     cs_n_d = 1'b1; sh_d = SH_DONE; adv = 1'b1;
                  end else if (opa == 4'd1) begin
                     cs_n_d = 1'b0; sh_d = SH_START; n1_done_d = 1'b0; n1_pend_d = 1'b0; adv = 1'b1;
                  end else begin
                     err_d = 1'b1; sh_d = SH_IDLE; st_d = SQ_IDLE;
                  end
               end
               OPN_SH_N1: begin
                  if (sh == SH_IDLE || sh == SH_DONE) begin
                     err_d = 1'b1; st_d = SQ_IDLE;
                  end else if ((n1_tx && !tdr_q) || (n1_rx && rdr_q)) begin
                     st_d = SQ_STALL; sh_d = SH_WAIT;
                  end else begin
                     sh_d = SH_N1;
                     tdr_clr = n1_tx;
                     if (nxt_is_n2) begin
                        n1_pend_d = 1'b1; n1_done_d = 1'b1; adv = 1'b1;
                     end else begin
                        st_d = SQ_FRAME; fr_n1_d = 1'b1; fr_n2_d = 1'b0; fr_rx_d = n1_rx;
                     end
                  end
               end
               OPN_SH_N2: begin
                  if (!n1_done_q) begin
                     err_d = 1'b1; st_d = SQ_IDLE;
                  end else if ((n2_rx || (n1_pend_q && n1_rx)) && rdr_q) begin
                     st_d = SQ_STALL; sh_d = SH_WAIT;
                  end else begin
                     sh_d = SH_N2; tdr_clr = n2_tx; st_d = SQ_FRAME;
                     fr_n1_d = n1_pend_q; fr_n2_d = 1'b1; fr_rx_d = n2_rx || (n1_pend_q && n1_rx);
                  end
               end
               OPN_BR_RDR: begin
                  if (!rdr_q) begin
                     st_d = SQ_STALL; sh_d = SH_WAIT;
                  end else begin
                     rdr_clr = 1'b1;
                     if (rdr_match) adv = 1'b1;
                     else           idx_d = opa[IDX_W-1:0];
                  end
               end
               default: begin
                  for (int k = 0; k < LOOPS; k++) begin
                     if (opn == OPN_LOOP0 + 4'(k)) begin
                        loop_hit = 1'b1;
                        if (!lp_hit[k]) begin
                           idx_d = opa[IDX_W-1:0]; lp_inc[k] = 1'b1;
                        end else adv = 1'b1;
                     end
                  end
                  if (!loop_hit) adv = 1'b1;
               end
            endcase
         end
      endcase
      if (adv) begin
         if (idx == IDX_W'(SLOTS-1)) begin
            st_d = SQ_IDLE; idx_d = '0; lp_clr = 1'b1;
         end else idx_d = idx + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= SQ_IDLE; sh <= SH_IDLE; idx <= '0; cs_n_q <= 1'b1; err_q <= 1'b0;
         tdr_q <= 1'b0; rdr_q <= 1'b0; n1_done_q <= 1'b0; n1_pend_q <= 1'b0;
         fr_n1_q <= 1'b0; fr_n2_q <= 1'b0; fr_rx_q <= 1'b0;
      end else if (soft_rst) begin
         st <= SQ_IDLE; sh <= SH_IDLE; idx <= '0; cs_n_q <= 1'b1; err_q <= 1'b0;
         tdr_q <= 1'b0; rdr_q <= 1'b0; n1_done_q <= 1'b0; n1_pend_q <= 1'b0;
         fr_n1_q <= 1'b0; fr_n2_q <= 1'b0; fr_rx_q <= 1'b0;
      end else begin
         st <= st_d; sh <= sh_d; idx <= idx_d; cs_n_q <= cs_n_d; err_q <= err_d;
         n1_done_q <= n1_done_d; n1_pend_q <= n1_pend_d;
         fr_n1_q <= fr_n1_d; fr_n2_q <= fr_n2_d; fr_rx_q <= fr_rx_d;
         tdr_q <= tdr_wr ? 1'b1 : (tdr_clr ? 1'b0 : tdr_q);
         rdr_q <= rdr_set ? 1'b1 : (rdr_clr ? 1'b0 : rdr_q);
      end
   end

   assign frame_req   = (st == SQ_FRAME);
   assign frame_n1    = fr_n1_q;
   assign frame_n2    = fr_n2_q;
   assign frame_rx    = fr_rx_q;
   assign cs_n        = cs_n_q;
   assign tdr_full    = tdr_q;
   assign rdr_full    = rdr_q;
   assign seq_idx     = idx;
   assign seq_state   = st;
   assign shift_state = sh;
   assign seq_err     = err_q;
endmodule

// File: rtl/spi_op_sequencer_chk.sv
module spi_op_sequencer_chk #(
   parameter int IDX_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tdr_wr,
   input logic             rstctl_wr,
   input logic             frame_done,
   input logic             frame_req,
   input logic             frame_rx,
   input logic             cs_n,
   input logic             rdr_full,
   input logic [IDX_W-1:0] seq_idx,
   input logic [1:0]       seq_state,
   input logic [2:0]       shift_state,
   input logic             seq_err
);
   AST_START_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_state == 2'd0 && tdr_wr) |=> (seq_idx == '0)); // R1

   AST_FRAME_WITH_CS: assert property (@(posedge clk) disable iff (!rst_n)
      frame_req |-> !cs_n); // R3

   AST_ERR_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(seq_err) |-> (seq_state == 2'd0)); // R4

   AST_STALL_IN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_state == 2'd3) |-> (shift_state == 3'd4)); // R6

   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_req && !frame_done && !rstctl_wr && !$past(rstctl_wr)) |=> frame_req); // R11

   AST_RX_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_req && frame_done && frame_rx && !$past(rstctl_wr)) |=> rdr_full); // R11
endmodule

bind spi_op_sequencer spi_op_sequencer_chk #(.IDX_W(IDX_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .tdr_wr(tdr_wr), .rstctl_wr(rstctl_wr),
   .frame_done(frame_done), .frame_req(frame_req), .frame_rx(frame_rx), .cs_n(cs_n),
   .rdr_full(rdr_full), .seq_idx(seq_idx), .seq_state(seq_state),
   .shift_state(shift_state), .seq_err(seq_err));

// File: tb/tb_spi_op_sequencer.sv
module tb_spi_op_sequencer;
   logic        clk = 1'b0, rst_n = 1'b0;
   logic [63:0] op_list = '0;
   logic [7:0]  loop_cmp = '0;
   logic        n1_tx = 0, n1_rx = 0, n2_tx = 0, n2_rx = 0, rdr_match = 0;
   logic        tdr_wr = 0, rdr_rd = 0, rstctl_wr = 0, frame_done = 0;
   logic [3:0]  rstctl_val = '0;
   logic        frame_req, frame_n1, frame_n2, frame_rx, cs_n, tdr_full, rdr_full, seq_err;
   logic [2:0]  seq_idx, shift_state;
   logic [1:0]  seq_state;
   int nchk = 0, nfail = 0, nfr = 0, dly = 1, cyc = 0;
   logic last_n1 = 0, last_n2 = 0, last_rx = 0;

   spi_op_sequencer dut (.*);

   always #2.5 clk = ~clk;

   always @(negedge clk) begin
      if (frame_done) frame_done = 1'b0;
      else if (frame_req) begin
         if (dly == 0) begin
            frame_done = 1'b1; nfr++;
            last_n1 = frame_n1; last_n2 = frame_n2; last_rx = frame_rx;
            dly = int'($urandom % 4);
         end else dly--;
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         nchk++; nfail++;
         $display("FAIL R1 watchdog actual=%0d expected=<150000", cyc);
         $display("%0d/%0d checks passed", nchk - nfail, nchk);
         $finish;
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int loop_frames(input int cmp);
      return cmp + 1;
   endfunction

   task automatic pulse_tdr();
      @(negedge clk) tdr_wr = 1'b1;
      @(negedge clk) tdr_wr = 1'b0;
   endtask

   task automatic pulse_rd();
      @(negedge clk) rdr_rd = 1'b1;
      @(negedge clk) rdr_rd = 1'b0;
   endtask

   task automatic key(input logic [3:0] v);
      @(negedge clk) begin rstctl_wr = 1'b1; rstctl_val = v; end
      @(negedge clk) rstctl_wr = 1'b0;
   endtask

   task automatic wait_st(input int target, input string tag);
      int n = 0;
      while (int'(seq_state) != target && n < 3000) begin
         @(negedge clk); n++;
      end
      chk(tag, int'(seq_state), target);
   endtask

   task automatic run(input logic [63:0] prog);
      op_list = prog; nfr = 0;
      pulse_tdr();
   endtask

   initial begin
      void'($urandom(32'd4242));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 state", seq_state, 0); chk("R1 idx", seq_idx, 0); chk("R1 cs_n", cs_n, 1);
      chk("R1 shift", shift_state, 0); chk("R1 err", seq_err, 0);
      chk("R1 tdr", tdr_full, 0); chk("R1 rdr", rdr_full, 0); chk("R1 req", frame_req, 0);

      // R2 / R11: lone transmitting N1
      n1_tx = 1;
      run(64'h11_31_10_00_00_00_00_00);
      chk("R1 run", seq_state, 1); chk("R1 idx0", seq_idx, 0); chk("R1 tdr set", tdr_full, 1);
      wait_st(0, "R2 idle");
      chk("R2 stop idx", seq_idx, 3); chk("R2 shift", shift_state, 0); chk("R3 cs rel", cs_n, 1);
      chk("R11 frames", nfr, 1); chk("R11 n1", last_n1, 1); chk("R11 n2", last_n2, 0);
      chk("R11 tdr clr", tdr_full, 0);

      // R6 stall on empty transmit, resume at same index
      run(64'h11_31_31_10_00_00_00_00);
      wait_st(3, "R6 stall");
      chk("R6 idx", seq_idx, 2); chk("R6 shift", shift_state, 4); chk("R6 frames", nfr, 1);
      pulse_tdr();
      chk("R6 resume st", seq_state, 1); chk("R6 resume idx", seq_idx, 2);
      wait_st(0, "R6 end");
      chk("R6 end idx", seq_idx, 4); chk("R6 total", nfr, 2);

      // R5 merged N1 + N2
      n1_tx = 1; n2_rx = 1;
      run(64'h11_32_44_10_00_00_00_00);
      wait_st(0, "R5 idle");
      chk("R5 frames", nfr, 1); chk("R5 n1", last_n1, 1); chk("R5 n2", last_n2, 1);
      chk("R5 rx", last_rx, 1); chk("R11 rdr set", rdr_full, 1); chk("R5 idx", seq_idx, 4);
      pulse_rd();
      chk("R11 rd clr", rdr_full, 0);

      // R4 N2 without N1
      n1_tx = 0; n2_rx = 0;
      run(64'h11_44_00_00_00_00_00_00);
      wait_st(0, "R4 idle");
      chk("R4 n2 err", seq_err, 1); chk("R4 n2 idx", seq_idx, 1); chk("R4 n2 frames", nfr, 0);

      // R10 reset key
      key(4'h5); key(4'h3); repeat (3) @(negedge clk);
      chk("R10 wrong key err", seq_err, 1); chk("R10 wrong key cs", cs_n, 0);
      key(4'h5); key(4'hA); repeat (3) @(negedge clk);
      chk("R10 err", seq_err, 0); chk("R10 cs", cs_n, 1); chk("R10 shift", shift_state, 0);

      // R4 N1 with shifter idle
      run(64'h31_00_00_00_00_00_00_00);
      wait_st(0, "R4 n1 idle");
      chk("R4 n1 err", seq_err, 1); chk("R4 n1 idx", seq_idx, 0); chk("R4 n1 frames", nfr, 0);

      // R3 bad select
      run(64'h11_13_00_00_00_00_00_00);
      wait_st(0, "R3 idle");
      chk("R3 err", seq_err, 1); chk("R3 idx", seq_idx, 1); chk("R3 cs held", cs_n, 0);
      chk("R3 shift", shift_state, 0);

      // R7 branch on receive match
      n1_rx = 1; rdr_match = 1;
      run(64'h11_31_65_10_00_10_00_00);
      wait_st(0, "R7 match");
      chk("R7 match idx", seq_idx, 4); chk("R7 match rdr", rdr_full, 0); chk("R7 frames", nfr, 1);
      rdr_match = 0;
      run(64'h11_31_65_10_00_10_00_00);
      wait_st(0, "R7 miss");
      chk("R7 miss idx", seq_idx, 6); chk("R7 miss rdr", rdr_full, 0);
      run(64'h11_62_00_00_00_00_00_00);
      wait_st(3, "R6 branch stall");
      chk("R6 br idx", seq_idx, 1); chk("R6 br shift", shift_state, 4);
      pulse_rd();
      chk("R6 br resume", seq_state, 1);
      wait_st(3, "R6 br restall");
      chk("R6 br restall idx", seq_idx, 1);
      key(4'h5); key(4'hA); repeat (3) @(negedge clk);
      chk("R10 exit stall", seq_state, 0);

      // R6 resume after receive-full stall via host read
      run(64'h11_31_31_10_00_00_00_00);
      wait_st(3, "R6 rx stall");
      chk("R6 rx idx", seq_idx, 2); chk("R6 rx full", rdr_full, 1); chk("R6 rx frames", nfr, 1);
      pulse_rd();
      chk("R6 rx resume", seq_state, 1); chk("R6 rx resume idx", seq_idx, 2);
      chk("R11 rx rd clr", rdr_full, 0);
      wait_st(0, "R6 rx end");
      chk("R6 rx end idx", seq_idx, 4); chk("R6 rx total", nfr, 2); chk("R11 rx refill", rdr_full, 1);
      pulse_rd();

      // R9 / R12 run off the end with unknown opcodes
      n1_rx = 0;
      run(64'h11_20_50_90_F0_A0_50_10);
      wait_st(0, "R9 idle");
      chk("R9 idx", seq_idx, 0); chk("R9 cs", cs_n, 1); chk("R9 shift done", shift_state, 5);
      chk("R12 err", seq_err, 0);

      // R8 loops: directed zero compare, then seeded random compare values
      loop_cmp = 8'h00;
      run(64'h11_30_71_10_00_00_00_00);
      wait_st(0, "R8 zero");
      chk("R8 zero frames", nfr, loop_frames(0));
      for (int i = 0; i < 8; i++) begin
         int k = int'($urandom % 2);
         int c = int'($urandom % 16);
         int o = int'($urandom % 16);
         loop_cmp = (k == 0) ? {o[3:0], c[3:0]} : {c[3:0], o[3:0]};
         run((k == 0) ? 64'h11_30_71_10_00_00_00_00 : 64'h11_30_81_10_00_00_00_00);
         wait_st(0, "R8 loop idle");
         chk($sformatf("R8 loop%0d cmp=%0d frames", k, c), nfr, loop_frames(c));
         chk("R8 loop idx", seq_idx, 4);
      end

      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end
endmodule